// File: doc/BRIEF.md
# Daisy-Chainable Serial Converter Front End

This block is the digital front end of a 12-bit serial-input converter. Serial data is shifted into a 12-bit input shift register, most significant bit first. Four strobe pins are merged into one shift clock. Three of them shift on a rising transition and one shifts on a falling transition. Holding any single strobe at its active level stops all further shifting.

The bit leaving the top of the shift register is presented on a registered serial output. This lets several devices share one data line in a daisy chain, with each device passing on the previous word while it takes in the next. Two active-low load pins, asserted together, copy the shift register in parallel into the converter register that drives the analog side. An asynchronous active-low clear forces the converter register to zero and leaves the shift register untouched.

All strobe, load and data pins are brought into the system clock domain through two-flop synchronisers before they are used.

Top module: `serdac_daisy`

## Requirements
- R1: After twelve shift events carrying word W most significant bit first, a load makes `dacCode` equal W.
- R2: `serialOut` equals the `serialIn` value captured twelve shift events earlier (zero until then), and changes only on a shift event.
- R3: A shift event occurs on a rising transition of `strobeRiseA`, `strobeRiseB` or `strobeRiseC`, or on a falling transition of `strobeFall`, provided no other strobe is active. The shift takes effect on the third rising `clk` edge after the pin changes.
- R4: While any one strobe is held active (high for the rise strobes, low for `strobeFall`), transitions on the other strobes cause no shift, and neither `serialOut` nor the shift register changes.
- R5: With only one of `loadAN` and `loadBN` low, `dacCode` keeps its value.
- R6: While both load pins are low, `dacCode` follows the shift register each clock, three `clk` edges behind the pins.
- R7: While `clearN` is low, `dacCode` is zero at once, without waiting for a clock edge, and this overrides an active load.
- R8: Clear leaves the shift register and `serialOut` unchanged, and shifting continues normally while clear is low.
- R9: After `rstN` the shift register, `serialOut` and `dacCode` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous system reset |
| strobeRiseA | input | 1 | Shift strobe, active on rising edge |
| strobeRiseB | input | 1 | Shift strobe, active on rising edge |
| strobeRiseC | input | 1 | Shift strobe, active on rising edge |
| strobeFall | input | 1 | Shift strobe, active on falling edge |
| loadAN | input | 1 | Active-low load, first of the pair |
| loadBN | input | 1 | Active-low load, second of the pair |
| clearN | input | 1 | Active-low asynchronous clear of the converter register |
| serialIn | input | 1 | Serial data input, MSB first |
| serialOut | output | 1 | Daisy-chain serial output |
| dacCode | output | 12 | Converter register value toward the analog side |

## Verification
The hardest situation to reach is a strobe held active while the others toggle. Taking the held strobe active is itself a shift, so the stimulus counts that shift in the reference model. It then toggles every other strobe with changing data and checks that the serial output and a later load show no extra shift. A second hard case is clear asserted while both loads stay low. The stimulus keeps the loads asserted, samples the converter code before the next clock edge to confirm the clear acts asynchronously, and keeps shifting under clear. It then releases clear and shows, through a fresh load, that the shift register kept its contents.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int WORD_W      = 12;
  localparam int SYNC_STAGES = 2;

  // positions of the pins inside the synchronised bundle
  localparam int PIN_RISE_A = 0;
  localparam int PIN_RISE_B = 1;
  localparam int PIN_RISE_C = 2;
  localparam int PIN_FALL   = 3;
  localparam int PIN_LOAD_A = 4;
  localparam int PIN_LOAD_B = 5;
  localparam int PIN_DATA   = 6;
  localparam int PIN_N      = 7;

  // idle levels: falling strobe and both loads rest high
  localparam logic [PIN_N-1:0] PIN_IDLE =
    (PIN_N'(1) << PIN_FALL) | (PIN_N'(1) << PIN_LOAD_A) | (PIN_N'(1) << PIN_LOAD_B);

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIN_N-1:0] pinSync,
  output ctrlStrobes_t     ctl,
  output logic             dataBit
);
  localparam int RISE_N = 3;

  logic [RISE_N-1:0] riseVec;
  logic combStrobe;
  logic combPrev;

  generate
    for (genvar g = 0; g < RISE_N; g++) begin : gRise
      assign riseVec[g] = pinSync[PIN_RISE_A + g];
    end
  endgenerate

  // any strobe at its active level keeps the merged strobe high
  assign combStrobe = (|riseVec) | ~pinSync[PIN_FALL];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) combPrev <= 1'b0;
    else       combPrev <= combStrobe;
  end

  assign ctl.shiftEn = combStrobe & ~combPrev;
  assign ctl.loadEn  = ~pinSync[PIN_LOAD_A] & ~pinSync[PIN_LOAD_B];
  assign dataBit     = pinSync[PIN_DATA];

  // a strobe held active over two cycles blocks shifting
  assert_block_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pinSync[PIN_RISE_A] && $past(pinSync[PIN_RISE_A])) |-> !ctl.shiftEn);
  assert_block_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!pinSync[PIN_FALL] && !$past(pinSync[PIN_FALL])) |-> !ctl.shiftEn);
  // falling strobe from fully idle gives a shift
  assert_fall_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pinSync[PIN_FALL]) && !$past(|riseVec)) |-> ctl.shiftEn);
endmodule

// File: rtl/serdac_datapath.sv
module serdac_datapath
  import serdac_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clearN,
  input  ctrlStrobes_t ctl,
  input  logic         dataBit,
  output logic         serialOut,
  output logic [W-1:0] dacCode
);
  logic [W-1:0] shiftReg;
  logic         sroQ;
  logic [W-1:0] dacReg;

  // input shift register and daisy-chain output flop; clear never touches them
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sroQ     <= 1'b0;
    end else if (ctl.shiftEn) begin
      shiftReg <= {shiftReg[W-2:0], dataBit};
      sroQ     <= shiftReg[W-1];
    end
  end

  // converter register with asynchronous clear taking priority over load
  always_ff @(posedge clk or negedge rstN or negedge clearN) begin
    if (!rstN)          dacReg <= '0;
    else if (!clearN)   dacReg <= '0;
    else if (ctl.loadEn) dacReg <= shiftReg;
  end

  assign serialOut = sroQ;
  assign dacCode   = dacReg;

  assert_shift_move_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shiftEn |=> shiftReg[W-1:1] == $past(shiftReg[W-2:0]));
  assert_sro_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.shiftEn |=> $stable(sroQ));
  assert_hold_dac_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && !ctl.loadEn) |=> ($stable(dacReg) || !clearN));
  assert_track_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clearN && ctl.loadEn) |=> (dacReg == $past(shiftReg) || !clearN));
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !clearN |-> dacReg == '0);
  assert_clear_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!clearN && !ctl.shiftEn) |=> $stable(shiftReg));
endmodule

// File: rtl/serdac_daisy.sv
module serdac_daisy
  import serdac_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         strobeRiseA,
  input  logic         strobeRiseB,
  input  logic         strobeRiseC,
  input  logic         strobeFall,
  input  logic         loadAN,
  input  logic         loadBN,
  input  logic         clearN,
  input  logic         serialIn,
  output logic         serialOut,
  output logic [W-1:0] dacCode
);
  logic [PIN_N-1:0] pinRaw;
  logic [PIN_N-1:0] pinSync;
  ctrlStrobes_t     ctl;
  logic             dataBit;

  always_comb begin
    pinRaw             = '0;
    pinRaw[PIN_RISE_A] = strobeRiseA;
    pinRaw[PIN_RISE_B] = strobeRiseB;
    pinRaw[PIN_RISE_C] = strobeRiseC;
    pinRaw[PIN_FALL]   = strobeFall;
    pinRaw[PIN_LOAD_A] = loadAN;
    pinRaw[PIN_LOAD_B] = loadBN;
    pinRaw[PIN_DATA]   = serialIn;
  end

  serdac_sync #(.WIDTH(PIN_N), .STAGES(STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rstN(rstN), .din(pinRaw), .dout(pinSync));

  serdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pinSync(pinSync), .ctl(ctl), .dataBit(dataBit));

  serdac_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .clearN(clearN), .ctl(ctl), .dataBit(dataBit),
    .serialOut(serialOut), .dacCode(dacCode));
endmodule

// File: tb/test_serdac_daisy.sv
module test_serdac_daisy;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeRiseA = 1'b0, strobeRiseB = 1'b0, strobeRiseC = 1'b0, strobeFall = 1'b1;
  logic loadAN = 1'b1, loadBN = 1'b1, clearN = 1'b1, serialIn = 1'b0;
  logic serialOut;
  logic [11:0] dacCode;

  int checks = 0;
  int errors = 0;
  logic [11:0] modelWord = '0;
  logic lastSro = 1'b0;
  logic expQ[$];
  event shiftDone;

  always #2 clk = ~clk;

  serdac_daisy i_serdac_daisy (
    .clk(clk), .rstN(rstN), .strobeRiseA(strobeRiseA), .strobeRiseB(strobeRiseB),
    .strobeRiseC(strobeRiseC), .strobeFall(strobeFall), .loadAN(loadAN), .loadBN(loadBN),
    .clearN(clearN), .serialIn(serialIn), .serialOut(serialOut), .dacCode(dacCode));

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setActive(int sel, logic on);
    case (sel)
      0: strobeRiseA = on;
      1: strobeRiseB = on;
      2: strobeRiseC = on;
      default: strobeFall = ~on;
    endcase
  endtask

  // driver: one shift through strobe sel, expectation queued for the monitor
  task automatic shiftBit(logic b, int sel);
    serialIn = b;
    idle(1);
    setActive(sel, 1'b1);
    idle(4);
    setActive(sel, 1'b0);
    idle(4);
    lastSro = modelWord[11];
    modelWord = {modelWord[10:0], b};
    expQ.push_back(lastSro);
    ->shiftDone;
  endtask

  task automatic shiftWord(logic [11:0] w, int sel, bit rotate);
    for (int i = 11; i >= 0; i--) shiftBit(w[i], rotate ? (i % 4) : sel);
  endtask

  task automatic loadPulse();
    loadAN = 1'b0; loadBN = 1'b0;
    idle(4);
  endtask

  task automatic loadRelease();
    loadAN = 1'b1; loadBN = 1'b1;
    idle(4);
  endtask

  // monitor: compares the daisy-chain output after each shift (R2)
  always @(shiftDone) begin
    #1;
    if (expQ.size() > 0) check("R2 serialOut", 12'(serialOut), 12'(expQ.pop_front()));
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [11:0] held;
    idle(5);
    rstN = 1'b1;
    idle(4);
    check("R9 dacCode after reset", dacCode, 12'h000);
    check("R9 serialOut after reset", 12'(serialOut), 12'h000);

    // R1: word through strobe A, then loaded
    shiftWord(12'hA5C, 0, 1'b0);
    loadPulse();
    check("R1 loaded word", dacCode, 12'hA5C);
    loadRelease();

    // R3: falling strobe alone, then all four strobes rotated
    shiftWord(12'h3E1, 3, 1'b0);
    loadPulse();
    check("R3 falling-strobe word", dacCode, 12'h3E1);
    loadRelease();
    shiftWord(12'h6B7, 0, 1'b1);
    loadPulse();
    check("R3 rotated-strobe word", dacCode, 12'h6B7);
    loadRelease();

    // R4: hold strobe A high (that edge shifts once), toggle the rest
    serialIn = 1'b1;
    idle(1);
    strobeRiseA = 1'b1;
    idle(4);
    lastSro = modelWord[11];
    modelWord = {modelWord[10:0], 1'b1};
    for (int k = 0; k < 6; k++) begin
      serialIn = k[0];
      setActive(1 + (k % 3), 1'b1);
      idle(4);
      setActive(1 + (k % 3), 1'b0);
      idle(4);
    end
    check("R4 serialOut while blocked", 12'(serialOut), 12'(lastSro));
    strobeRiseA = 1'b0;
    idle(4);
    check("R4 serialOut after release", 12'(serialOut), 12'(lastSro));
    loadPulse();
    check("R4 no extra shift", dacCode, modelWord);
    loadRelease();

    // R5: one load at a time has no effect
    held = dacCode;
    shiftWord(12'h15A, 1, 1'b0);
    loadAN = 1'b0;
    idle(5);
    check("R5 only loadAN low", dacCode, held);
    loadAN = 1'b1; loadBN = 1'b0;
    idle(5);
    check("R5 only loadBN low", dacCode, held);
    loadBN = 1'b1;
    idle(4);

    // R6: tracking while both loads stay low
    loadPulse();
    check("R6 initial copy", dacCode, 12'h15A);
    shiftBit(1'b1, 2);
    check("R6 track after shift 1", dacCode, modelWord);
    shiftBit(1'b0, 3);
    check("R6 track after shift 2", dacCode, modelWord);

    // R7: asynchronous clear beats the active load
    clearN = 1'b0;
    #1;
    check("R7 clear before clock edge", dacCode, 12'h000);
    idle(5);
    check("R7 clear over load", dacCode, 12'h000);

    // R8: shifting under clear, register kept
    shiftBit(1'b1, 0);
    shiftBit(1'b1, 3);
    check("R8 dacCode still clear", dacCode, 12'h000);
    loadRelease();
    clearN = 1'b1;
    idle(4);
    check("R8 zero after clear release", dacCode, 12'h000);
    loadPulse();
    check("R8 shift register kept", dacCode, modelWord);
    loadRelease();

    idle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule